// File: doc/BRIEF.md
# Three-Modulus Mixed-Radix Digit Converter

This block turns a residue-number-system value over the moduli 2^n+1, 2^n and 2^n-1 into its three mixed-radix digits. These digits give the weighted form X = d1 + d2·(2^n+1) + d3·(2^n+1)·2^n without rebuilding X in binary. Downstream logic can then make magnitude decisions, such as a sign test or an overflow test, from the top digits alone.

The moduli are taken in a fixed order: the 2^n+1 channel first, then 2^n, then 2^n-1. In that order every modular inverse the conversion needs is either 1 or 2^(n-1). The datapath is therefore one wrap-around subtractor, single-bit rotations, inversions and two end-around-carry adders, with no multipliers and no tables. The width n is a parameter. A second parameter selects between a purely combinational output and a registered output with a valid flag.

Top module: `mrd_digit_conv`

## Requirements
- R1: The first digit `e1_o` equals the 2^n+1 residue `x1_i` unchanged, all n+1 bits.
- R2: The second digit `e2_o` equals (x2 − x1) mod 2^n, where only bits [n-1:0] of `x1_i` take part.
- R3: The third digit `e3_o` equals (2^(n-1)·(x3 − x1) − e2) mod (2^n−1).
- R4: `e3_o` never carries the all-ones code. A zero residue in the 2^n−1 channel is always reported as 0, so `e3_o` lies in 0..2^n−2.
- R5: When `x1_i` equals 2^n (bit n set, low bits zero), `e2_o` equals `x2_i` and `e3_o` still satisfies R3.
- R6: For every legal X in 0..M−1, where M = 2^n(2^n+1)(2^n−1), the digits obtained from the residues of X satisfy e1 + e2·(2^n+1) + e3·(2^n+1)·2^n = X.
- R7: With the registered output selected, `out_valid` is high in the cycle after a cycle with `in_valid` high, and low after a cycle with `in_valid` low. The digits belong to the inputs of that earlier cycle. With the combinational output, the digits follow the inputs in the same cycle.
- R8: With the registered output selected, synchronous reset clears `out_valid` and all three digits to zero.
- R9: With the registered output selected, the digits hold their last value while `in_valid` is low, whatever the residue inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the registered output |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Residue inputs carry a value this cycle |
| x1_i | input | N+1 | Residue modulo 2^N+1 |
| x2_i | input | N | Residue modulo 2^N |
| x3_i | input | N | Residue modulo 2^N−1 |
| out_valid | output | 1 | Digits carry a result |
| e1_o | output | N+1 | Lowest mixed-radix digit, weight 1 |
| e2_o | output | N | Middle digit, weight 2^N+1 |
| e3_o | output | N | Top digit, weight (2^N+1)·2^N |

## Verification
Two conditions are hard to reach by hand. One is the residue value 2^n in the first channel, which selects the constant term. The other is an end-around sum that lands on the all-ones pattern, which must fold to zero. Both occur only for particular X values, so the stimulus starts from every integer in the dynamic range for n=4 and derives each residue triple from it. That covers every case where x1=2^n and every all-ones sum. The expected digits come from integer division of X. A combinational copy at n=2 is also swept over its whole range, and two worked values are checked explicitly: 49 gives digits (4,1,2) and 21 gives digits (1,0,1).

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

    // modulus of the first channel, 2^n+1
    function automatic int unsigned mod_plus(input int unsigned n);
        return (32'd1 << n) + 32'd1;
    endfunction

    // modulus of the third channel, 2^n-1
    function automatic int unsigned mod_minus(input int unsigned n);
        return (32'd1 << n) - 32'd1;
    endfunction

endpackage

// File: rtl/mrd_pow2_sub.sv
// Second digit: difference of residues modulo 2^N (natural wrap).
module mrd_pow2_sub #(
    parameter int N = 4
) (
    input  logic [N-1:0] minuend,
    input  logic [N-1:0] subtrahend,
    output logic [N-1:0] diff
);
    always_comb begin
        diff = minuend - subtrahend;
    end
endmodule

// File: rtl/mrd_x1_term.sv
// Term -2^(N-1)*x1 mod (2^N-1) from the (N+1)-bit first residue.
module mrd_x1_term #(
    parameter int N = 4
) (
    input  logic [N:0]   x1,
    output logic [N-1:0] term
);
    logic [N-1:0] low_rot;

    always_comb begin
        low_rot = {x1[0], x1[N-1:1]};
        if (x1[N]) begin
            // x1 == 2^N, which is 1 modulo 2^N-1
            term = {1'b0, {(N-1){1'b1}}};
        end else begin
            term = ~low_rot;
        end
    end
endmodule

// File: rtl/mrd_eac_add.sv
// Two-operand modulo 2^N-1 adder with end-around carry.
module mrd_eac_add #(
    parameter int N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] s
);
    logic [N:0] raw;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        s   = raw[N-1:0] + {{(N-1){1'b0}}, raw[N]};
    end
endmodule

// File: rtl/mrd_m3_sum3.sv
// Three-operand modulo 2^N-1 sum, result normalised to 0..2^N-2.
module mrd_m3_sum3 #(
    parameter int N = 4
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic [N-1:0] op_c,
    output logic [N-1:0] sum
);
    localparam int STAGES = 2;

    logic [N-1:0] addend [STAGES];
    logic [N-1:0] acc    [STAGES+1];

    assign addend[0] = op_b;
    assign addend[1] = op_c;
    assign acc[0]    = op_a;

    for (genvar g = 0; g < STAGES; g++) begin : g_chain
        mrd_eac_add #(.N(N)) u_add (
            .a (acc[g]),
            .b (addend[g]),
            .s (acc[g+1])
        );
    end

    always_comb begin
        sum = (acc[STAGES] == {N{1'b1}}) ? '0 : acc[STAGES];
    end
endmodule

// File: rtl/mrd_digit_conv.sv
module mrd_digit_conv #(
    parameter int                N        = 4,
    parameter mrd_pkg::out_mode_e OUT_MODE = mrd_pkg::OUT_REG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [N:0]   x1_i,
    input  logic [N-1:0] x2_i,
    input  logic [N-1:0] x3_i,
    output logic         out_valid,
    output logic [N:0]   e1_o,
    output logic [N-1:0] e2_o,
    output logic [N-1:0] e3_o
);
    localparam int unsigned M1    = mrd_pkg::mod_plus(N);
    localparam int unsigned M3    = mrd_pkg::mod_minus(N);
    localparam logic [N:0]  X1TOP = (N+1)'(M1 - 1);
    localparam logic [N-1:0] ONES = (N)'(M3);

    typedef struct packed {
        logic [N:0]   d1;
        logic [N-1:0] d2;
        logic [N-1:0] d3;
    } digits_t;

    digits_t      nxt;
    logic [N-1:0] d2_w;
    logic [N-1:0] x3_rot;
    logic [N-1:0] x1_term;
    logic [N-1:0] d2_neg;
    logic [N-1:0] d3_w;

    mrd_pow2_sub #(.N(N)) u_sub (
        .minuend    (x2_i),
        .subtrahend (x1_i[N-1:0]),
        .diff       (d2_w)
    );

    mrd_x1_term #(.N(N)) u_term (
        .x1   (x1_i),
        .term (x1_term)
    );

    always_comb begin
        x3_rot = {x3_i[0], x3_i[N-1:1]};
        d2_neg = ~d2_w;
    end

    mrd_m3_sum3 #(.N(N)) u_sum (
        .op_a (x3_rot),
        .op_b (x1_term),
        .op_c (d2_neg),
        .sum  (d3_w)
    );

    always_comb begin
        nxt.d1 = x1_i;
        nxt.d2 = d2_w;
        nxt.d3 = d3_w;
    end

    if (OUT_MODE == mrd_pkg::OUT_REG) begin : g_reg
        digits_t q;
        logic    vq;

        always_ff @(posedge clk) begin
            if (rst) begin
                q  <= '0;
                vq <= 1'b0;
            end else begin
                vq <= in_valid;
                if (in_valid) begin
                    q <= nxt;
                end
            end
        end

        assign out_valid = vq;
        assign e1_o      = q.d1;
        assign e2_o      = q.d2;
        assign e3_o      = q.d3;

        AST_E1_PASS: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (e1_o == $past(x1_i))); // R1
        AST_E3_NO_ONES: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (e3_o != ONES)); // R4
        AST_TOP_X1: assert property (@(posedge clk) disable iff (rst)
            (in_valid && x1_i == X1TOP) |=> (e2_o == $past(x2_i))); // R5
        AST_VALID_SET: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid); // R7
        AST_VALID_CLR: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid); // R7
        AST_HOLD: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> ($stable(e1_o) && $stable(e2_o) && $stable(e3_o))); // R9
    end else begin : g_comb
        assign out_valid = in_valid;
        assign e1_o      = nxt.d1;
        assign e2_o      = nxt.d2;
        assign e3_o      = nxt.d3;
    end

endmodule

// File: tb/tb_mrd_digit_conv.sv
module tb_mrd_digit_conv;
    localparam int N   = 4;
    localparam int P1  = (1 << N) + 1;
    localparam int P2  = (1 << N);
    localparam int P3  = (1 << N) - 1;
    localparam int MR  = P1 * P2 * P3;
    localparam int NS  = 2;
    localparam int S1  = (1 << NS) + 1;
    localparam int S2  = (1 << NS);
    localparam int S3  = (1 << NS) - 1;

    typedef struct {
        int x;
        int d1;
        int d2;
        int d3;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [N:0]   x1 = '0;
    logic [N-1:0] x2 = '0;
    logic [N-1:0] x3 = '0;
    logic         ov;
    logic [N:0]   e1;
    logic [N-1:0] e2;
    logic [N-1:0] e3;

    logic [NS:0]   s_x1 = '0;
    logic [NS-1:0] s_x2 = '0;
    logic [NS-1:0] s_x3 = '0;
    logic          s_ov;
    logic [NS:0]   s_e1;
    logic [NS-1:0] s_e2;
    logic [NS-1:0] s_e3;

    int   errors = 0;
    int   checks = 0;
    bit   finished = 1'b0;
    exp_t sb[$];
    exp_t last_exp;

    always #4 clk = ~clk;

    mrd_digit_conv #(.N(N), .OUT_MODE(mrd_pkg::OUT_REG)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .x1_i(x1), .x2_i(x2), .x3_i(x3),
        .out_valid(ov), .e1_o(e1), .e2_o(e2), .e3_o(e3)
    );

    mrd_digit_conv #(.N(NS), .OUT_MODE(mrd_pkg::OUT_COMB)) dut_n2 (
        .clk(clk), .rst(rst), .in_valid(1'b1),
        .x1_i(s_x1), .x2_i(s_x2), .x3_i(s_x3),
        .out_valid(s_ov), .e1_o(s_e1), .e2_o(s_e2), .e3_o(s_e3)
    );

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic send(input int xv);
        exp_t t;
        t.x  = xv;
        t.d1 = xv % P1;
        t.d2 = (xv / P1) % P2;
        t.d3 = xv / (P1 * P2);
        @(negedge clk);
        x1 = (N+1)'(xv % P1);
        x2 = N'(xv % P2);
        x3 = N'(xv % P3);
        in_valid = 1'b1;
        sb.push_back(t);
        last_exp = t;
    endtask

    // combinational n=2 copy: whole range plus the two worked values
    task automatic small_case(input int xv);
        int d1;
        int d2;
        int d3;
        s_x1 = (NS+1)'(xv % S1);
        s_x2 = NS'(xv % S2);
        s_x3 = NS'(xv % S3);
        #1;
        d1 = xv % S1;
        d2 = (xv / S1) % S2;
        d3 = xv / (S1 * S2);
        check("R7 comb valid", int'(s_ov), 1);
        check("R6 n2 recon", int'(s_e1) + int'(s_e2) * S1 + int'(s_e3) * S1 * S2, xv);
        check("R2 n2 e2", int'(s_e2), d2);
        check("R3 n2 e3", int'(s_e3), d3);
        check("R1 n2 e1", int'(s_e1), d1);
    endtask

    // monitor: pops the scoreboard as results appear
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && ov) begin
                if (sb.size() == 0) begin
                    check("R7 unexpected out_valid", 1, 0);
                end else begin
                    exp_t t;
                    t = sb.pop_front();
                    check("R1 e1", int'(e1), t.d1);
                    check("R2 e2", int'(e2), t.d2);
                    if (t.d1 == P2) check("R5 e3 at x1=2^n", int'(e3), t.d3);
                    else            check("R3 e3", int'(e3), t.d3);
                    checks++;
                    if (e3 == {N{1'b1}}) begin
                        errors++;
                        $display("FAIL R4 actual=%0d expected<%0d", e3, P3);
                    end
                    check("R6 recon", int'(e1) + int'(e2) * P1 + int'(e3) * P1 * P2, t.x);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        small_case(49);
        check("R3 n2 worked 49 e3", int'(s_e3), 2);
        check("R2 n2 worked 49 e2", int'(s_e2), 1);
        small_case(21);
        check("R3 n2 worked 21 e3", int'(s_e3), 1);
        check("R2 n2 worked 21 e2", int'(s_e2), 0);
        for (int k = 0; k < S1 * S2 * S3; k++) small_case(k);

        // R8: reset state
        x1 = '1; x2 = '1; x3 = '1; in_valid = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        check("R8 out_valid", int'(ov), 0);
        check("R8 e1", int'(e1), 0);
        check("R8 e2", int'(e2), 0);
        check("R8 e3", int'(e3), 0);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b0;

        // full sweep of the dynamic range, with gaps for R7
        for (int k = 0; k < MR; k++) begin
            send(k);
            if (k % 97 == 5) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;

        // R9: hold while idle, with scrambled inputs
        x1 = 5'd3; x2 = 4'd9; x3 = 4'd7;
        repeat (3) @(posedge clk);
        #2;
        check("R7 idle out_valid", int'(ov), 0);
        check("R9 hold e1", int'(e1), last_exp.d1);
        check("R9 hold e2", int'(e2), last_exp.d2);
        check("R9 hold e3", int'(e3), last_exp.d3);
        check("R7 scoreboard drained", sb.size(), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule